// File: doc/BRIEF.md
# Serial Register Loader for an Eight-Channel Volume Array

This block takes register writes from a three-wire serial link (an active-low select, a serial clock and a data line) and keeps the register file that controls an eight-channel, 8-bit attenuator/converter array. A host lowers the select, sends a 4-bit register address and then an 8-bit data byte, both most significant bit first, on rising serial-clock edges, and raises the select again. The write takes effect only if exactly twelve rising clock edges arrived during that select window.

All link inputs are brought into the system clock domain through two-stage synchronizers with edge detection. The serial clock must run at no more than a quarter of the system clock rate. The register file presents, as parallel outputs, eight channel codes, a 2-bit reference-source choice for each channel, a bypass flag for each channel and a power-down flag for each channel.

Top module: `tri_wire_volume_regs`

## Requirements
- R1: Serial clock edges while `cs_n` is high are ignored: they change no output and do not disturb the next frame.
- R2: Data is sampled on the rising edge of `sck` while `cs_n` is low. The first four bits form the address, MSB first, and the next eight bits form the data byte, MSB first.
- R3: A frame of exactly twelve rising edges is committed when `cs_n` rises, and the new value appears on the outputs by the third rising `clk` edge after `cs_n` goes high.
- R4: A frame with fewer than twelve rising edges (for example 1 or 11) changes no output.
- R5: A frame with more than twelve rising edges (for example 13 or 16) changes no output.
- R6: Addresses 0 to 7 write the 8-bit code of channels 0 to 7. Channel n occupies `ch_code[8n+7:8n]`.
- R7: Address 8 holds the reference selects of channels 0 to 3, and address 9 holds those of channels 4 to 7. Each channel uses two bits, with the lower channel in the lower bits (channel n of the group in data bits [2k+1:2k], k = n mod 4). The encoding is 0 = external reference, 1 = ground, 2 = analog supply, 3 = half supply. Channel n appears on `ref_sel[2n+1:2n]`.
- R8: Address 10 writes the bypass flags, with data bit n going to `bypass[n]`.
- R9: Address 11 writes the power-down flags, with data bit n going to `pdown[n]`.
- R10: Writes to addresses 12 to 15 change no output.
- R11: While `rst_n` is low, and after it is released, all codes read 0x00, every reference select reads 0 (external), all bypass flags read 0 and all power-down flags read 1.
- R12: Consecutive frames are each committed on their own, and a later write to the same address replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sck | input | 1 | Serial clock, rising edge samples data |
| sdi | input | 1 | Serial data in |
| ch_code | output | 64 | Eight 8-bit channel codes, channel 0 in the low byte |
| ref_sel | output | 16 | Eight 2-bit reference-source selects |
| bypass | output | 8 | Per-channel converter bypass flag |
| pdown | output | 8 | Per-channel buffer power-down flag |

## Verification
The hardest cases to reach are frames whose length is off by one: eleven or thirteen edges. In these frames the address and data bits look valid, so only the edge count keeps the write from landing. The stimulus task takes an explicit edge count. It sends the leading bits of a real write to a live register and pads the extra bits with zeros, so a design that commits on a length near twelve would visibly corrupt an output. Serial clock pulses with the select high are also sent ahead of a valid frame, to show they leave neither the outputs nor the framing disturbed.

// File: rtl/vol_pkg.sv
package vol_pkg;
    localparam int unsigned NCH_DEF    = 8;
    localparam int unsigned CODE_W_DEF = 8;
    localparam int unsigned ADDR_W_DEF = 4;
    localparam int unsigned REF_W      = 2;

    typedef enum logic [REF_W-1:0] {
        REF_EXTERNAL = 2'd0,
        REF_GROUND   = 2'd1,
        REF_SUPPLY   = 2'd2,
        REF_HALF     = 2'd3
    } ref_src_e;
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic meta;
        logic stable;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = din;
        st_d.stable = st_q.meta;
        st_d.prev   = st_q.stable;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{meta: RST_VAL, stable: RST_VAL, prev: RST_VAL};
        else        st_q <= st_d;
    end

    assign level_o = st_q.stable;
    assign rise_o  = st_q.stable & ~st_q.prev;
    assign fall_o  = ~st_q.stable & st_q.prev;
endmodule

// File: rtl/frame_deser.sv
module frame_deser #(
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              cs_rise,
    input  logic              cs_fall,
    input  logic              sck_rise,
    input  logic              sdi_lvl,
    output logic              commit_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [$clog2(ADDR_W+DATA_W+2)-1:0] cnt_o
);
    localparam int unsigned FRAME_W = ADDR_W + DATA_W;
    localparam int unsigned CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

    typedef struct packed {
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
    } deser_t;

    deser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cs_fall) begin
            st_d.cnt = '0;
        end else if (cs_low && sck_rise) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], sdi_lvl};
            if (st_q.cnt != CNT_SAT) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign commit_o = cs_rise && (st_q.cnt == CNT_FULL);
    assign addr_o   = st_q.shreg[FRAME_W-1:DATA_W];
    assign data_o   = st_q.shreg[DATA_W-1:0];
    assign cnt_o    = st_q.cnt;
endmodule

// File: rtl/vol_reg_bank.sv
module vol_reg_bank
    import vol_pkg::*;
#(
    parameter int unsigned NCH    = 8,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [CODE_W-1:0]       wr_data,
    output logic [NCH*CODE_W-1:0]   code_o,
    output logic [NCH*REF_W-1:0]    rsel_o,
    output logic [NCH-1:0]          byp_o,
    output logic [NCH-1:0]          pd_o
);
    localparam int unsigned REF_PER_REG = CODE_W / REF_W;
    localparam int unsigned REF_REGS    = NCH / REF_PER_REG;
    localparam int unsigned A_REF0      = NCH;
    localparam int unsigned A_BYP       = NCH + REF_REGS;
    localparam int unsigned A_PD        = A_BYP + 1;

    typedef struct packed {
        logic [NCH-1:0][CODE_W-1:0] code;
        logic [NCH-1:0][REF_W-1:0]  rsel;
        logic [NCH-1:0]             byp;
        logic [NCH-1:0]             pd;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_addr == ADDR_W'(c)) st_d.code[c] = wr_data;
            end
            for (int r = 0; r < REF_REGS; r++) begin
                if (wr_addr == ADDR_W'(A_REF0 + r)) begin
                    for (int k = 0; k < REF_PER_REG; k++) begin
                        st_d.rsel[r*REF_PER_REG + k] = wr_data[k*REF_W +: REF_W];
                    end
                end
            end
            if (wr_addr == ADDR_W'(A_BYP)) st_d.byp = wr_data[NCH-1:0];
            if (wr_addr == ADDR_W'(A_PD))  st_d.pd  = wr_data[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= '0;
            st_q.rsel <= {NCH{REF_EXTERNAL}};
            st_q.byp  <= '0;
            st_q.pd   <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign rsel_o = st_q.rsel;
    assign byp_o  = st_q.byp;
    assign pd_o   = st_q.pd;
endmodule

// File: rtl/tri_wire_volume_regs.sv
module tri_wire_volume_regs
    import vol_pkg::*;
#(
    parameter int unsigned NCH    = NCH_DEF,
    parameter int unsigned CODE_W = CODE_W_DEF,
    parameter int unsigned ADDR_W = ADDR_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sck,
    input  logic                  sdi,
    output logic [NCH*CODE_W-1:0] ch_code,
    output logic [NCH*REF_W-1:0]  ref_sel,
    output logic [NCH-1:0]        bypass,
    output logic [NCH-1:0]        pdown
);
    localparam int unsigned CNT_W = $clog2(ADDR_W + CODE_W + 2);

    logic cs_lvl, cs_hi_rise, cs_hi_fall;
    logic sck_lvl, sck_rise, sck_fall;
    logic sdi_lvl, sdi_rise, sdi_fall;
    logic              wr_stb;
    logic [ADDR_W-1:0] wr_addr;
    logic [CODE_W-1:0] wr_data;
    logic [CNT_W-1:0]  bit_cnt;

    edge_sync #(.RST_VAL(1'b1)) i_cs_sync (
        .clk(clk), .rst_n(rst_n), .din(cs_n),
        .level_o(cs_lvl), .rise_o(cs_hi_rise), .fall_o(cs_hi_fall)
    );

    edge_sync #(.RST_VAL(1'b0)) i_sck_sync (
        .clk(clk), .rst_n(rst_n), .din(sck),
        .level_o(sck_lvl), .rise_o(sck_rise), .fall_o(sck_fall)
    );

    edge_sync #(.RST_VAL(1'b0)) i_sdi_sync (
        .clk(clk), .rst_n(rst_n), .din(sdi),
        .level_o(sdi_lvl), .rise_o(sdi_rise), .fall_o(sdi_fall)
    );

    frame_deser #(.ADDR_W(ADDR_W), .DATA_W(CODE_W)) i_deser (
        .clk(clk), .rst_n(rst_n),
        .cs_low(~cs_lvl), .cs_rise(cs_hi_rise), .cs_fall(cs_hi_fall),
        .sck_rise(sck_rise), .sdi_lvl(sdi_lvl),
        .commit_o(wr_stb), .addr_o(wr_addr), .data_o(wr_data), .cnt_o(bit_cnt)
    );

    vol_reg_bank #(.NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) i_bank (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .code_o(ch_code), .rsel_o(ref_sel), .byp_o(bypass), .pd_o(pdown)
    );

    logic unused_edges;
    assign unused_edges = sck_lvl ^ sck_fall ^ sdi_rise ^ sdi_fall;
endmodule

// File: rtl/vol_regs_chk.sv
module vol_regs_chk #(
    parameter int unsigned NCH    = 8,
    parameter int unsigned CODE_W = 8,
    parameter int unsigned ADDR_W = 4,
    parameter int unsigned CNT_W  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cs_lvl,
    input logic                  cs_fall,
    input logic                  sck_rise,
    input logic                  commit,
    input logic [ADDR_W-1:0]     waddr,
    input logic [CODE_W-1:0]     wdata,
    input logic [CNT_W-1:0]      cnt,
    input logic [NCH*CODE_W-1:0] ch_code,
    input logic [NCH*2-1:0]      ref_sel,
    input logic [NCH-1:0]        bypass,
    input logic [NCH-1:0]        pdown
);
    localparam int unsigned FRAME_W = ADDR_W + CODE_W;
    localparam int unsigned TOP_ADDR = NCH + (NCH * 2) / CODE_W + 2;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(FRAME_W + 1)); // R5

    AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall |=> cnt == '0); // R2

    AST_IDLE_SCK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_lvl && !cs_fall) |=> $stable(cnt)); // R1

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(ch_code) && $stable(ref_sel) && $stable(bypass) && $stable(pdown))); // R4

    AST_CODE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && waddr < ADDR_W'(NCH)) |=>
            ch_code[int'($past(waddr))*CODE_W +: CODE_W] == $past(wdata)); // R6

    AST_HIGH_ADDR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && waddr >= ADDR_W'(TOP_ADDR)) |=>
            ($stable(ch_code) && $stable(ref_sel) && $stable(bypass) && $stable(pdown))); // R10

    AST_COMMIT_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> cs_lvl); // R3

    logic unused_in;
    assign unused_in = sck_rise;
endmodule

bind tri_wire_volume_regs vol_regs_chk #(
    .NCH(NCH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
) i_chk (
    .clk(clk), .rst_n(rst_n), .cs_lvl(cs_lvl), .cs_fall(cs_hi_fall),
    .sck_rise(sck_rise), .commit(wr_stb), .waddr(wr_addr), .wdata(wr_data),
    .cnt(bit_cnt), .ch_code(ch_code), .ref_sel(ref_sel),
    .bypass(bypass), .pdown(pdown)
);

// File: tb/test_tri_wire_volume_regs.sv
module test_tri_wire_volume_regs;
    localparam int NCH = 8;
    localparam int HB  = 4;   // serial half period in clk cycles

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic sdi = 1'b0;
    logic [NCH*8-1:0] ch_code;
    logic [NCH*2-1:0] ref_sel;
    logic [NCH-1:0]   bypass;
    logic [NCH-1:0]   pdown;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] exp_code [NCH];
    logic [1:0] exp_ref  [NCH];
    logic [NCH-1:0] exp_byp;
    logic [NCH-1:0] exp_pd;

    always #2 clk = ~clk;

    tri_wire_volume_regs i_tri_wire_volume_regs (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
        .ch_code(ch_code), .ref_sel(ref_sel), .bypass(bypass), .pdown(pdown)
    );

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            exp_code[i] = 8'h00;
            exp_ref[i]  = 2'd0;
        end
        exp_byp = '0;
        exp_pd  = '1;
    endtask

    task automatic model_write(input logic [3:0] a, input logic [7:0] d);
        if (a < 4'd8) exp_code[a] = d;
        else if (a == 4'd8) for (int k = 0; k < 4; k++) exp_ref[k] = d[2*k +: 2];
        else if (a == 4'd9) for (int k = 0; k < 4; k++) exp_ref[4+k] = d[2*k +: 2];
        else if (a == 4'd10) exp_byp = d;
        else if (a == 4'd11) exp_pd = d;
    endtask

    task automatic check_all(input string req);
        for (int i = 0; i < NCH; i++) begin
            n_checks++;
            if (ch_code[8*i +: 8] !== exp_code[i]) begin
                n_fail++;
                $display("FAIL %s ch%0d code got %h exp %h", req, i, ch_code[8*i +: 8], exp_code[i]);
            end
            n_checks++;
            if (ref_sel[2*i +: 2] !== exp_ref[i]) begin
                n_fail++;
                $display("FAIL %s ch%0d ref got %0d exp %0d", req, i, ref_sel[2*i +: 2], exp_ref[i]);
            end
        end
        n_checks++;
        if (bypass !== exp_byp) begin
            n_fail++;
            $display("FAIL %s bypass got %b exp %b", req, bypass, exp_byp);
        end
        n_checks++;
        if (pdown !== exp_pd) begin
            n_fail++;
            $display("FAIL %s pdown got %b exp %b", req, pdown, exp_pd);
        end
    endtask

    // Sends nbits rising edges; bits beyond the 12-bit word are zero.
    // Leaves cs_n high on the edge just sampled, so three ticks later the commit is visible.
    task automatic send_frame(input logic [3:0] a, input logic [7:0] d, input int nbits);
        logic [11:0] word;
        word = {a, d};
        tick(HB);
        cs_n = 1'b0;
        tick(HB);
        for (int i = 0; i < nbits; i++) begin
            sdi = (i < 12) ? word[11-i] : 1'b0;
            tick(HB);
            sck = 1'b1;
            tick(HB);
            sck = 1'b0;
        end
        tick(HB);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic t_reset();
        model_reset();
        check_all("R11");
    endtask

    task automatic t_codes();
        send_frame(4'd0, 8'h01, 12); model_write(4'd0, 8'h01);
        send_frame(4'd1, 8'h80, 12); model_write(4'd1, 8'h80);
        check_all("R2");
        send_frame(4'd2, 8'hA5, 12); model_write(4'd2, 8'hA5);
        send_frame(4'd3, 8'h5A, 12); model_write(4'd3, 8'h5A);
        send_frame(4'd4, 8'hFF, 12); model_write(4'd4, 8'hFF);
        send_frame(4'd5, 8'h3C, 12); model_write(4'd5, 8'h3C);
        send_frame(4'd6, 8'hC3, 12); model_write(4'd6, 8'hC3);
        send_frame(4'd7, 8'h7E, 12); model_write(4'd7, 8'h7E);
        check_all("R6");
    endtask

    task automatic t_commit_timing();
        send_frame(4'd5, 8'h99, 12); model_write(4'd5, 8'h99);
        check_all("R3");
    endtask

    task automatic t_refsel();
        send_frame(4'd8, 8'b11_10_01_00, 12); model_write(4'd8, 8'b11_10_01_00);
        send_frame(4'd9, 8'b00_01_10_11, 12); model_write(4'd9, 8'b00_01_10_11);
        check_all("R7");
    endtask

    task automatic t_flags();
        send_frame(4'd10, 8'h5A, 12); model_write(4'd10, 8'h5A);
        check_all("R8");
        send_frame(4'd11, 8'h0F, 12); model_write(4'd11, 8'h0F);
        check_all("R9");
    endtask

    task automatic t_short();
        send_frame(4'd0, 8'hEE, 11);
        check_all("R4");
        send_frame(4'd10, 8'hFF, 1);
        check_all("R4");
    endtask

    task automatic t_long();
        send_frame(4'd0, 8'hFE, 13);
        check_all("R5");
        send_frame(4'd11, 8'hF0, 16);
        check_all("R5");
    endtask

    task automatic t_high_addr();
        for (int a = 12; a < 16; a++) send_frame(4'(a), 8'hFF, 12);
        check_all("R10");
    endtask

    task automatic t_idle_clock();
        tick(HB);
        for (int i = 0; i < 5; i++) begin
            sdi = i[0];
            tick(HB);
            sck = 1'b1;
            tick(HB);
            sck = 1'b0;
        end
        tick(HB);
        check_all("R1");
        send_frame(4'd6, 8'h42, 12); model_write(4'd6, 8'h42);
        check_all("R1");
    endtask

    task automatic t_back_to_back();
        send_frame(4'd3, 8'h11, 12); model_write(4'd3, 8'h11);
        send_frame(4'd4, 8'h22, 12); model_write(4'd4, 8'h22);
        send_frame(4'd3, 8'h33, 12); model_write(4'd3, 8'h33);
        check_all("R12");
    endtask

    initial begin
        model_reset();
        tick(3);
        check_all("R11");
        rst_n = 1'b1;
        tick(4);
        t_reset();
        t_codes();
        t_commit_timing();
        t_refsel();
        t_flags();
        t_short();
        t_long();
        t_high_addr();
        t_idle_clock();
        t_back_to_back();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired got running exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule